// File: doc/BRIEF.md
# Stretched Trigger Pulse Domain Crossing

This block moves single-cycle trigger events from one clock into a second clock that has no phase or frequency relation to the first. In the launching domain each trigger is held as a level for a fixed number of launch cycles. The count is chosen from the clock ratio, so the level stays valid for longer than one receiving period plus setup and hold margin. If the first receiving edge resolves the level to 0, the following receiving edge still finds it high.

In the receiving domain the level passes through a chain of flip-flops whose length is a parameter. The default is two; high-reliability uses take three or more. A rising-edge detector follows the chain. The synchronized level may stay high for one or two receiving cycles, and the detector reduces that to exactly one receiving-cycle pulse per trigger. The block carries no data. Triggers must be spaced further apart than the stretch length; a trigger that arrives while a stretch is still running lengthens that stretch instead of making a second event.

Top module: `pulse_xfer`

## Requirements
- R1: While the launch-side reset is high, the stretched level and its counter clear to 0. A trigger presented in a cycle where that reset is also high produces no receive-side pulse.
- R2: A trigger sampled high on a launch clock edge makes the stretched level high from that edge on.
- R3: Without a new trigger, the stretched level stays high for exactly STRETCH_CYCLES launch cycles (default 2) and then falls.
- R4: A trigger sampled while the level is already high restarts the count, so the level stays high without a break. Such merged triggers give exactly one receive-side pulse.
- R5: Each isolated trigger produces exactly one receive-side pulse, and every receive-side pulse lasts exactly one receive clock cycle. This holds across different phase offsets between the clocks.
- R6: While the receive-side reset is high, every synchronizer stage and the edge-detector register clear to 0, and the output pulse is 0 in the cycle after reset was sampled. A trigger whose stretch completes entirely inside receive reset is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Launch-domain clock |
| src_rst | input | 1 | Launch-domain synchronous reset, active high |
| src_pulse | input | 1 | Single-cycle trigger in the launch domain |
| dst_clk | input | 1 | Receive-domain clock |
| dst_rst | input | 1 | Receive-domain synchronous reset, active high |
| dst_pulse | output | 1 | One-cycle pulse in the receive domain |

## Verification
Two launch-side actions can fall in the same cycle: reloading the stretch counter for a new trigger, and counting down or ending a stretch that is already running. The bench provokes this with two patterns. In one, two triggers arrive on consecutive launch cycles. In the other, a trigger, an idle cycle and a second trigger arrive while the first stretch is still high. Each pattern is judged by counting receive-side pulses, and exactly one must appear. A third collision is a trigger that coincides with launch reset. Reset must win and no pulse may appear.

// File: rtl/pulse_xfer_pkg.sv
package pulse_xfer_pkg;

    // Width of a counter that must hold values 0 .. n-1 (at least one bit).
    function automatic int cnt_width(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

    // State of the receive-side edge detector.
    typedef struct packed {
        logic cur;
        logic prev;
    } edge_state_t;

endpackage

// File: rtl/pulse_widen.sv
module pulse_widen #(
    parameter int STRETCH_CYCLES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic level
);
    localparam int CW = pulse_xfer_pkg::cnt_width(STRETCH_CYCLES);
    localparam logic [CW-1:0] RELOAD = CW'(STRETCH_CYCLES - 1);

    logic [CW-1:0] remain_q;
    logic          level_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
            level_q  <= 1'b0;
        end else if (trig) begin
            remain_q <= RELOAD;
            level_q  <= 1'b1;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - CW'(1);
        end else begin
            level_q  <= 1'b0;
        end
    end

    assign level = level_q;
endmodule

// File: rtl/level_sync.sv
module level_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/rise_detect.sv
module rise_detect (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic pulse
);
    pulse_xfer_pkg::edge_state_t st;

    assign st.cur = lvl;

    always_ff @(posedge clk) begin
        if (rst) st.prev <= 1'b0;
        else     st.prev <= st.cur;
    end

    assign pulse = st.cur & ~st.prev;
endmodule

// File: rtl/pulse_xfer.sv
module pulse_xfer #(
    parameter int STRETCH_CYCLES = 2,
    parameter int SYNC_STAGES    = 2
) (
    input  logic src_clk,
    input  logic src_rst,
    input  logic src_pulse,
    input  logic dst_clk,
    input  logic dst_rst,
    output logic dst_pulse
);
    logic src_level;
    logic dst_level;

    pulse_widen #(.STRETCH_CYCLES(STRETCH_CYCLES)) u_widen (
        .clk   (src_clk),
        .rst   (src_rst),
        .trig  (src_pulse),
        .level (src_level)
    );

    level_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (dst_clk),
        .rst  (dst_rst),
        .din  (src_level),
        .dout (dst_level)
    );

    rise_detect u_edge (
        .clk   (dst_clk),
        .rst   (dst_rst),
        .lvl   (dst_level),
        .pulse (dst_pulse)
    );
endmodule

// File: rtl/pulse_xfer_chk.sv
module pulse_xfer_chk #(
    parameter int STRETCH_CYCLES = 2
) (
    input logic src_clk,
    input logic src_rst,
    input logic src_pulse,
    input logic src_level,
    input logic dst_clk,
    input logic dst_rst,
    input logic dst_pulse
);
    // Counts how many launch cycles the stretched level has been high.
    logic [15:0] hi_run;

    always_ff @(posedge src_clk) begin
        if (src_rst)        hi_run <= '0;
        else if (src_level) hi_run <= (hi_run == 16'hFFFF) ? hi_run : hi_run + 16'd1;
        else                hi_run <= '0;
    end

    a_r1_src_reset_clears: assert property (@(posedge src_clk)
        src_rst |=> !src_level);

    a_r2_level_rises: assert property (@(posedge src_clk) disable iff (src_rst)
        src_pulse |=> src_level);

    a_r3_min_stretch: assert property (@(posedge src_clk) disable iff (src_rst)
        (!src_level && $past(src_level) && !$past(src_rst)) |-> (hi_run >= 16'(STRETCH_CYCLES)));

    a_r5_single_cycle: assert property (@(posedge dst_clk) disable iff (dst_rst)
        dst_pulse |=> !dst_pulse);

    a_r6_dst_reset_quiet: assert property (@(posedge dst_clk)
        dst_rst |=> !dst_pulse);
endmodule

bind pulse_xfer pulse_xfer_chk #(.STRETCH_CYCLES(STRETCH_CYCLES)) u_chk (
    .src_clk   (src_clk),
    .src_rst   (src_rst),
    .src_pulse (src_pulse),
    .src_level (src_level),
    .dst_clk   (dst_clk),
    .dst_rst   (dst_rst),
    .dst_pulse (dst_pulse)
);

// File: tb/pulse_xfer_tb.sv
`timescale 1ns/100ps
module pulse_xfer_tb;
    logic src_clk = 1'b0;
    logic dst_clk = 1'b0;
    logic src_rst = 1'b1;
    logic dst_rst = 1'b1;
    logic src_pulse = 1'b0;
    logic dst_pulse;

    int checks = 0;
    int errors = 0;
    int seen   = 0;
    int wide   = 0;
    logic last_seen = 1'b0;
    bit   done = 1'b0;

    // 250 MHz receive clock; launch clock 6.6 ns, not an integer multiple of 4 ns.
    always #2.0 dst_clk = ~dst_clk;
    always #3.3 src_clk = ~src_clk;

    pulse_xfer #(.STRETCH_CYCLES(2), .SYNC_STAGES(2)) u_dut (
        .src_clk  (src_clk),
        .src_rst  (src_rst),
        .src_pulse(src_pulse),
        .dst_clk  (dst_clk),
        .dst_rst  (dst_rst),
        .dst_pulse(dst_pulse)
    );

    // Pulse counter and width monitor, sampled away from the active edge.
    always @(negedge dst_clk) begin
        if (dst_pulse) seen <= seen + 1;
        if (dst_pulse && last_seen) wide <= wide + 1;
        last_seen <= dst_pulse;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic src_idle(input int n);
        for (int i = 0; i < n; i++) @(negedge src_clk);
    endtask

    // mode 0: single trigger; 1: two consecutive; 2: trigger, idle, trigger
    task automatic fire(input int mode);
        @(negedge src_clk); src_pulse = 1'b1;
        @(negedge src_clk);
        if (mode == 1) begin
            @(negedge src_clk);
        end else if (mode == 2) begin
            src_pulse = 1'b0;
            @(negedge src_clk); src_pulse = 1'b1;
            @(negedge src_clk);
        end
        src_pulse = 1'b0;
    endtask

    // Each entry: {phase offset in launch cycles, mode}
    localparam int NV = 8;
    localparam int VEC_OFS  [NV] = '{0, 1, 3, 2, 5, 0, 4, 1};
    localparam int VEC_MODE [NV] = '{0, 0, 0, 1, 0, 2, 1, 2};

    initial begin
        #200000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        src_idle(4);
        @(negedge dst_clk);
        chk("R6 reset output", int'(dst_pulse), 0);
        src_rst = 1'b0;
        dst_rst = 1'b0;
        src_idle(6);
        chk("R6 idle after reset", seen, 0);

        // Vector walk: each trigger pattern must yield exactly one pulse.
        for (int v = 0; v < NV; v++) begin
            src_idle(VEC_OFS[v]);
            #(0.7 * v);
            seen = 0;
            fire(VEC_MODE[v]);
            src_idle(14);
            if (VEC_MODE[v] == 0) chk("R2 R3 R5 single trigger", seen, 1);
            else                  chk("R4 merged trigger", seen, 1);
        end
        chk("R5 pulse width one cycle", wide, 0);

        // R1: trigger coincides with launch reset; reset wins.
        seen = 0;
        @(negedge src_clk); src_rst = 1'b1; src_pulse = 1'b1;
        @(negedge src_clk); src_rst = 1'b0; src_pulse = 1'b0;
        src_idle(14);
        chk("R1 trigger under reset dropped", seen, 0);
        seen = 0;
        fire(0);
        src_idle(14);
        chk("R1 recovery after reset", seen, 1);

        // R6: stretch completes entirely inside receive reset.
        @(negedge dst_clk); dst_rst = 1'b1;
        seen = 0;
        fire(0);
        src_idle(10);
        @(negedge dst_clk);
        chk("R6 output low in reset", int'(dst_pulse), 0);
        dst_rst = 1'b0;
        src_idle(12);
        chk("R6 trigger during reset dropped", seen, 0);
        seen = 0;
        fire(0);
        src_idle(14);
        chk("R6 recovery after reset", seen, 1);
        chk("R5 final width", wide, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule